// File: doc/BRIEF.md
# Segment-Based Address Translator

This block turns a two-part logical address (a segment index and a byte offset within that segment) into a physical address. It holds a small table on chip. Each row of the table stores the physical start of a segment, the segment's length in bytes and a flag that marks the row as in use. A requester presents the segment index and the offset together with a strobe. One cycle later the block answers with either the physical address or a fault code.

Rows of the table can only be loaded through a configuration port, and only when that port's supervisor qualifier is asserted. A load attempted without the qualifier leaves the table untouched and raises a one-cycle violation flag. Before the base is added, the offset is compared with the stored length. An offset that reaches or passes the length yields a bounds fault and no address. A row not marked in use yields an invalid-segment fault.

Top module: `seg_xlate_unit`

## Requirements
- R1: A configuration write with `cfg_we=1` and `cfg_priv=1` stores `cfg_base`, `cfg_limit` and `cfg_valid` in row `cfg_seg`. Requests issued from the next cycle onward see the new row.
- R2: A configuration write with `cfg_we=1` and `cfg_priv=0` leaves the table unchanged. `priv_err` is high in exactly the cycle after such a write and low after any other cycle.
- R3: `rsp_vld` equals `req_vld` delayed by one clock cycle.
- R4: For a row in use with `req_off < limit`, the response carries `rsp_pa = (base + req_off) mod 2^PA_W`, `rsp_cause = 2'b00` and `rsp_fault = 0`. The sum wraps at the top of the physical space.
- R5: For a row in use with `req_off >= limit`, the response carries `rsp_cause = 2'b01`, `rsp_fault = 1` and `rsp_pa = 0`. A limit of zero therefore faults every offset.
- R6: For a row not in use, the response carries `rsp_cause = 2'b10`, `rsp_fault = 1` and `rsp_pa = 0`, whatever the offset and the stored limit. The code `2'b11` never appears.
- R7: A synchronous active-low reset marks every row as not in use and drives `rsp_vld`, `rsp_pa`, `rsp_cause`, `rsp_fault` and `priv_err` to zero.
- R8: When a request and a privileged write to the same row share a cycle, the request is translated with the row's contents from before the write.
- R9: In any cycle where `rsp_vld` is low, `rsp_pa`, `rsp_cause` and `rsp_fault` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_priv | input | 1 | Supervisor qualifier for the write |
| cfg_seg | input | SEG_W | Row addressed by the write |
| cfg_base | input | PA_W | Physical start of the segment |
| cfg_limit | input | OFF_W+1 | Segment length in bytes |
| cfg_valid | input | 1 | Marks the row as in use |
| priv_err | output | 1 | Pulses one cycle after an unqualified write |
| req_vld | input | 1 | Translation request strobe |
| req_seg | input | SEG_W | Segment index of the request |
| req_off | input | OFF_W | Offset within the segment |
| rsp_vld | output | 1 | Response strobe, one cycle after the request |
| rsp_pa | output | PA_W | Physical address, zero on a fault |
| rsp_fault | output | 1 | High when the response is a fault |
| rsp_cause | output | 2 | 00 none, 01 bounds, 10 invalid segment |

## Verification
Two functions can land in the same cycle: a table load and a translation of the same row. A load and a rejected unqualified load can also coincide with a request. The bench forces these collisions in a directed run. It writes a new base into row 1 in the same cycle as a request to row 1, and then requests row 1 again. The first answer must carry the old base and the second the new one. A long random phase follows, with writes and requests crossing freely, and it is judged on every clock against a behavioural table model. That model resolves each cycle by reading before it updates.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE    = 2'b00,
      CAUSE_BOUNDS  = 2'b01,
      CAUSE_INVALID = 2'b10
   } cause_e;
endpackage

// File: rtl/seg_priv_gate.sv
module seg_priv_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic priv,
   output logic we_ok,
   output logic viol_q
);
   assign we_ok = we & priv;

   always_ff @(posedge clk) begin
      if (!rst_n) viol_q <= 1'b0;
      else        viol_q <= we & ~priv;
   end
endmodule

// File: rtl/seg_table.sv
module seg_table #(
   parameter int SEG_W      = 3,
   parameter int PA_W       = 16,
   parameter int LIM_W      = 11,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEG_W-1:0] wr_seg,
   input  logic [PA_W-1:0]  wr_base,
   input  logic [LIM_W-1:0] wr_lim,
   input  logic             wr_vld,
   input  logic [SEG_W-1:0] rd_seg,
   output logic [PA_W-1:0]  rd_base,
   output logic [LIM_W-1:0] rd_lim,
   output logic             rd_vld
);
   localparam int NSEG = 1 << SEG_W;

   logic [PA_W-1:0]  base_q [NSEG];
   logic [LIM_W-1:0] lim_q  [NSEG];
   logic [NSEG-1:0]  vld_q;

   // the in-use flags always reset; data registers only when asked
   always_ff @(posedge clk) begin
      if (!rst_n)     vld_q <= '0;
      else if (wr_en) vld_q[wr_seg] <= wr_vld;
   end

   generate
      if (RESET_DATA) begin : g_data_rst
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < NSEG; i++) begin
                  base_q[i] <= '0;
                  lim_q[i]  <= '0;
               end
            end else if (wr_en) begin
               base_q[wr_seg] <= wr_base;
               lim_q[wr_seg]  <= wr_lim;
            end
         end
      end else begin : g_data_norst
         always_ff @(posedge clk) begin
            if (wr_en) begin
               base_q[wr_seg] <= wr_base;
               lim_q[wr_seg]  <= wr_lim;
            end
         end
      end
   endgenerate

   // read returns the stored row, so a same-cycle write is not seen
   assign rd_base = base_q[rd_seg];
   assign rd_lim  = lim_q[rd_seg];
   assign rd_vld  = vld_q[rd_seg];
endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check
   import seg_xlate_pkg::*;
#(
   parameter int OFF_W = 10,
   parameter int PA_W  = 16,
   parameter int LIM_W = 11
) (
   input  logic             row_vld,
   input  logic [PA_W-1:0]  row_base,
   input  logic [LIM_W-1:0] row_lim,
   input  logic [OFF_W-1:0] off,
   output logic [PA_W-1:0]  pa,
   output cause_e           cause
);
   localparam int PAD_LIM = LIM_W - OFF_W;
   localparam int PAD_PA  = PA_W - OFF_W;

   logic [LIM_W-1:0] off_l;
   logic [PA_W-1:0]  off_p;
   logic             in_range;

   assign off_l    = {{PAD_LIM{1'b0}}, off};
   assign off_p    = {{PAD_PA{1'b0}}, off};
   assign in_range = off_l < row_lim;

   always_comb begin
      pa    = '0;
      cause = CAUSE_NONE;
      if (!row_vld)       cause = CAUSE_INVALID;
      else if (!in_range) cause = CAUSE_BOUNDS;
      else                pa    = row_base + off_p;
   end
endmodule

// File: rtl/seg_resp_reg.sv
module seg_resp_reg
   import seg_xlate_pkg::*;
#(
   parameter int PA_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_vld,
   input  logic [PA_W-1:0] in_pa,
   input  cause_e          in_cause,
   output logic            out_vld,
   output logic [PA_W-1:0] out_pa,
   output logic [1:0]      out_cause,
   output logic            out_fault
);
   always_ff @(posedge clk) begin
      if (!rst_n || !in_vld) begin
         out_vld   <= 1'b0;
         out_pa    <= '0;
         out_cause <= 2'b00;
         out_fault <= 1'b0;
      end else begin
         out_vld   <= 1'b1;
         out_pa    <= in_pa;
         out_cause <= in_cause;
         out_fault <= (in_cause != CAUSE_NONE);
      end
   end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W      = 3,
   parameter int OFF_W      = 10,
   parameter int PA_W       = 16,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_priv,
   input  logic [SEG_W-1:0]   cfg_seg,
   input  logic [PA_W-1:0]    cfg_base,
   input  logic [OFF_W:0]     cfg_limit,
   input  logic               cfg_valid,
   output logic               priv_err,
   input  logic               req_vld,
   input  logic [SEG_W-1:0]   req_seg,
   input  logic [OFF_W-1:0]   req_off,
   output logic               rsp_vld,
   output logic [PA_W-1:0]    rsp_pa,
   output logic               rsp_fault,
   output logic [1:0]         rsp_cause
);
   localparam int LIM_W = OFF_W + 1;

   generate
      if (SEG_W < 1 || SEG_W > 8) begin : g_bad_seg
         $error("seg_xlate_unit: SEG_W must lie in 1..8");
      end
      if (OFF_W < 1) begin : g_bad_off
         $error("seg_xlate_unit: OFF_W must be positive");
      end
      if (PA_W < OFF_W) begin : g_bad_pa
         $error("seg_xlate_unit: PA_W must not be narrower than OFF_W");
      end
   endgenerate

   logic             we_ok;
   logic [PA_W-1:0]  row_base;
   logic [LIM_W-1:0] row_lim;
   logic             row_vld;
   logic [PA_W-1:0]  xl_pa;
   cause_e           xl_cause;

   seg_priv_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .priv   (cfg_priv),
      .we_ok  (we_ok),
      .viol_q (priv_err)
   );

   seg_table #(
      .SEG_W      (SEG_W),
      .PA_W       (PA_W),
      .LIM_W      (LIM_W),
      .RESET_DATA (RESET_DATA)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (we_ok),
      .wr_seg  (cfg_seg),
      .wr_base (cfg_base),
      .wr_lim  (cfg_limit),
      .wr_vld  (cfg_valid),
      .rd_seg  (req_seg),
      .rd_base (row_base),
      .rd_lim  (row_lim),
      .rd_vld  (row_vld)
   );

   seg_bound_check #(
      .OFF_W (OFF_W),
      .PA_W  (PA_W),
      .LIM_W (LIM_W)
   ) u_check (
      .row_vld  (row_vld),
      .row_base (row_base),
      .row_lim  (row_lim),
      .off      (req_off),
      .pa       (xl_pa),
      .cause    (xl_cause)
   );

   seg_resp_reg #(
      .PA_W (PA_W)
   ) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (req_vld),
      .in_pa     (xl_pa),
      .in_cause  (xl_cause),
      .out_vld   (rsp_vld),
      .out_pa    (rsp_pa),
      .out_cause (rsp_cause),
      .out_fault (rsp_fault)
   );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int SEG_W = 3,
   parameter int OFF_W = 10,
   parameter int PA_W  = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic             cfg_priv,
   input logic             priv_err,
   input logic             req_vld,
   input logic             rsp_vld,
   input logic [PA_W-1:0]  rsp_pa,
   input logic             rsp_fault,
   input logic [1:0]       rsp_cause
);
   assert_rsp_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_vld);

   assert_no_stray_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !rsp_vld);

   assert_viol_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_priv) |=> priv_err);

   assert_viol_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && !cfg_priv) |=> !priv_err);

   assert_bounds_zero_pa_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_cause == 2'b01) |-> (rsp_pa == '0 && rsp_fault));

   assert_invalid_zero_pa_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_cause == 2'b10) |-> (rsp_pa == '0 && rsp_fault));

   assert_no_code_11_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_cause != 2'b11);

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_vld |-> (rsp_pa == '0 && rsp_cause == 2'b00 && !rsp_fault));

   assert_reset_clears_R7: assert property (@(posedge clk)
      !rst_n |=> (!rsp_vld && !priv_err && !rsp_fault));
endmodule

bind seg_xlate_unit seg_xlate_chk #(
   .SEG_W (SEG_W),
   .OFF_W (OFF_W),
   .PA_W  (PA_W)
) u_chk (.*);

// File: tb/seg_xlate_unit_bench.sv
module seg_xlate_unit_bench;
   localparam int SEG_W = 3;
   localparam int OFF_W = 10;
   localparam int PA_W  = 16;
   localparam int NSEG  = 1 << SEG_W;
   localparam int PAMOD = 1 << PA_W;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cfg_we = 1'b0, cfg_priv = 1'b0, cfg_valid = 1'b0;
   logic [SEG_W-1:0]   cfg_seg = '0;
   logic [PA_W-1:0]    cfg_base = '0;
   logic [OFF_W:0]     cfg_limit = '0;
   logic               req_vld = 1'b0;
   logic [SEG_W-1:0]   req_seg = '0;
   logic [OFF_W-1:0]   req_off = '0;
   logic               priv_err, rsp_vld, rsp_fault;
   logic [PA_W-1:0]    rsp_pa;
   logic [1:0]         rsp_cause;

   always #5 clk = ~clk;

   seg_xlate_unit u_seg_xlate_unit (.*);

   // behavioural table model
   int  m_base [NSEG];
   int  m_lim  [NSEG];
   bit  m_use  [NSEG];
   int  e_pa, e_cause;
   bit  e_vld, e_viol, e_coll, e_rst;
   int  n_chk = 0, n_err = 0;
   bit  done = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_use[i]) begin m_use[i] = 1'b0; m_base[i] = 0; m_lim[i] = 0; end
         e_vld = 0; e_pa = 0; e_cause = 0; e_viol = 0; e_coll = 0; e_rst = 1;
      end else begin
         e_rst  = 0;
         e_vld  = req_vld;
         e_pa   = 0;
         e_cause = 0;
         e_coll = req_vld && cfg_we && cfg_priv && (cfg_seg == req_seg);
         if (req_vld) begin
            if (!m_use[req_seg])                   e_cause = 2;
            else if (int'(req_off) >= m_lim[req_seg]) e_cause = 1;
            else e_pa = (m_base[req_seg] + int'(req_off)) % PAMOD;
         end
         e_viol = cfg_we && !cfg_priv;
         // table update after the lookup (R8 ordering)
         if (cfg_we && cfg_priv) begin
            m_base[cfg_seg] = int'(cfg_base);
            m_lim[cfg_seg]  = int'(cfg_limit);
            m_use[cfg_seg]  = cfg_valid;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         string t;
         if (e_rst)               t = "R7";
         else if (e_coll)         t = "R8";
         else if (e_cause == 2)   t = "R6";
         else if (e_cause == 1)   t = "R5";
         else                     t = "R4";
         chk(rsp_vld == e_vld, e_rst ? "R7" : "R3", int'(rsp_vld), int'(e_vld));
         chk(priv_err == e_viol, e_rst ? "R7" : "R2", int'(priv_err), int'(e_viol));
         if (e_vld) begin
            chk(int'(rsp_pa) == e_pa, t, int'(rsp_pa), e_pa);
            chk(int'(rsp_cause) == e_cause, t, int'(rsp_cause), e_cause);
            chk(rsp_fault == (e_cause != 0), t, int'(rsp_fault), int'(e_cause != 0));
         end else begin
            chk(rsp_pa == '0 && rsp_cause == 2'b00 && !rsp_fault,
                e_rst ? "R7" : "R9", int'(rsp_pa) + int'(rsp_cause), 0);
         end
      end
   end

   task automatic step(input bit we, input bit pv, input int seg, input int base,
                       input int lim, input bit use_row, input bit rq,
                       input int rseg, input int roff);
      @(negedge clk);
      cfg_we    = we;
      cfg_priv  = pv;
      cfg_seg   = SEG_W'(seg);
      cfg_base  = PA_W'(base);
      cfg_limit = (OFF_W+1)'(lim);
      cfg_valid = use_row;
      req_vld   = rq;
      req_seg   = SEG_W'(rseg);
      req_off   = OFF_W'(roff);
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_err++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      // R7: reset window
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(0,0,0,0,0,0, 1,0,5);                  // R6 row unused after reset
      step(1,1,1,16'h1000,100,1, 0,0,0);         // R1 load row 1
      step(0,0,0,0,0,0, 1,1,0);                  // R4 first byte
      step(0,0,0,0,0,0, 1,1,99);                 // R4 last legal byte
      step(0,0,0,0,0,0, 1,1,100);                // R5 offset equals length
      step(1,0,1,16'h2000,500,1, 0,0,0);         // R2 unqualified write
      step(0,0,0,0,0,0, 1,1,5);                  // R2 row 1 still old: 0x1005
      step(1,1,1,16'h3000,100,1, 1,1,7);         // R8 collision, old base
      step(0,0,0,0,0,0, 1,1,7);                  // R1 new base 0x3007
      step(1,1,2,16'h0400,0,1, 0,0,0);           // zero length row
      step(0,0,0,0,0,0, 1,2,0);                  // R5 limit zero
      step(1,1,3,16'hFF00,1024,1, 0,0,0);
      step(0,0,0,0,0,0, 1,3,1023);               // R4 wrap to 0x02FF
      step(1,1,4,16'h0800,1024,0, 0,0,0);
      step(0,0,0,0,0,0, 1,4,3);                  // R6 row not in use
      step(1,0,4,0,0,0, 1,3,2);                  // R2 with request alongside
      step(0,0,0,0,0,0, 0,0,0);                  // R9 idle
      // R7: mid-run reset wipes the in-use flags
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      step(0,0,0,0,0,0, 1,1,7);                  // R6 after reset
      // random crossing of writes and requests
      for (int k = 0; k < 3000; k++) begin
         step($urandom_range(0,3) == 0, $urandom_range(0,4) != 0,
              $urandom_range(0,NSEG-1), $urandom_range(0,PAMOD-1),
              $urandom_range(0,1 << OFF_W), $urandom_range(0,5) != 0,
              $urandom_range(0,2) != 0, $urandom_range(0,NSEG-1),
              $urandom_range(0,(1 << OFF_W)-1));
      end
      step(0,0,0,0,0,0, 0,0,0);
      @(negedge clk);
      @(posedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule